// File: doc/BRIEF.md
# Disk DMA Mode and Status Register

This block is the CPU-facing mode-control and status word pair of a disk DMA channel that serves both a floppy controller and a hard-disk controller. A word written to the mode register drives the controller's two address lines. The same word chooses which register set (floppy or hard disk) the sector count refers to and whether window accesses reach the controller or the sector count register. It also gates DMA, picks the floppy or hard-disk path and sets the transfer direction. Reading the same location returns an active-low status word: no-error, sector-count-nonzero and data-request-inactive.

The block also holds a 24-bit DMA address. The CPU loads it one byte at a time, and it advances by one sector (512 bytes) each time the transfer engine reports a completed sector. Flipping the direction bit is the software's way to reset the channel: it clears the error state and zeroes both sector counts. Byte-width accesses to the mode/status location are refused with a bus error.

Top module: `dma_mode_status`

## Requirements
- R1: A word write to select 1 stores mode bits: bits 2:1 drive `ctrl_a_o` (bit 1 is A0), bit 3 drives `reg_set_hd_o`, bit 4 drives `cnt_sel_o`, bit 6 drives `dma_en_o`, bit 7 drives `path_hd_o`, bit 8 drives `to_disk_o` (1 = memory to disk). Bits 0, 5 and 15:9 have no effect. The outputs change on the clock edge of the write.
- R2: A word mode write whose bit 8 differs from the stored bit 8 clears the error state and zeroes both sector counts. A mode write that keeps bit 8 leaves them unchanged.
- R3: A read of select 1 returns status: bit 0 = NOT error, bit 1 = 1 when the count chosen by `reg_set_hd_o` is nonzero, bit 2 = NOT `drq_i`. Bits 15:3 are 0.
- R4: `err_i` high at a clock edge sets a sticky error state. If it coincides with a direction flip, the error is still set.
- R5: A byte-width (`byte_i`=1) read or write of select 1 raises `bus_err_o` in that cycle, changes no state and reads as 0.
- R6: Selects 2, 3 and 4 hold DMA address bits 23:16, 15:8 and 7:0. They are written from `wdata_i[7:0]` and read in `rdata_o[7:0]`. Address bit 0 is always 0.
- R7: `sector_done_i` adds 512 to the DMA address, modulo 2^24. A CPU write to any address byte in the same cycle takes priority, and the address does not advance.
- R8: Select 0 is the controller window. With `cnt_sel_o`=1, a write loads the sector count chosen by `reg_set_hd_o` from `wdata_i[7:0]`, and a read returns that count. With `cnt_sel_o`=0, a write pulses `ctrl_wr_o` and a read returns `ctrl_rdata_i`.
- R9: `sector_done_i` decrements the count chosen by `reg_set_hd_o` when it is nonzero, and a zero count stays 0. A direction flip in the same cycle wins and leaves 0.
- R10: After reset the mode is 0, both counts and the address are 0, the error state is clear, and status reads 0x0005 with `drq_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Register select (0 window, 1 mode/status, 2..4 address high/mid/low) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| byte_i | input | 1 | Access is byte-wide |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (0 when no read) |
| bus_err_o | output | 1 | Bus error for byte access to mode/status |
| ctrl_rdata_i | input | 16 | Data read back from the selected controller |
| ctrl_wr_o | output | 1 | Write strobe forwarded to the controller |
| ctrl_a_o | output | 2 | Controller register address lines |
| reg_set_hd_o | output | 1 | Sector count set: 1 hard disk, 0 floppy |
| cnt_sel_o | output | 1 | Window targets the sector count register |
| dma_en_o | output | 1 | DMA enable |
| path_hd_o | output | 1 | Hard-disk path selected |
| to_disk_o | output | 1 | Direction, 1 = memory to disk |
| dma_addr_o | output | 24 | Current DMA address |
| err_i | input | 1 | Transfer error report |
| drq_i | input | 1 | Data request from the controller |
| sector_done_i | input | 1 | One sector transferred |

## Verification
Two pairs of functions can act in the same cycle. A sector completion can arrive while the CPU flips the direction bit, so the count reset and the decrement collide. A sector completion can also arrive while the CPU writes an address byte, so the load and the 512-byte advance collide. The bench drives `sector_done_i` in the very cycle of such a write. It then reads the count back through the window, or watches `dma_addr_o`, and expects the CPU action to win in both cases. It also raises `err_i` on the same edge as a direction flip and expects status bit 0 to stay low.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int SEL_W    = 3;
  localparam int SEL_WIN  = 0;
  localparam int SEL_MODE = 1;
  localparam int SEL_AHI  = 2;
  localparam int SEL_AMID = 3;
  localparam int SEL_ALO  = 4;

  typedef struct packed {
    logic       to_disk;
    logic       path_hd;
    logic       dma_en;
    logic       cnt_sel;
    logic       reg_set_hd;
    logic [1:0] ctrl_a;
  } mode_t;

  function automatic mode_t decode_mode(input logic [15:0] w);
    mode_t m;
    m.ctrl_a     = w[2:1];
    m.reg_set_hd = w[3];
    m.cnt_sel    = w[4];
    m.dma_en     = w[6];
    m.path_hd    = w[7];
    m.to_disk    = w[8];
    return m;
  endfunction
endpackage

// File: rtl/dma_mode_reg.sv
module dma_mode_reg
  import dma_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] wdata_i,
  output mode_t       mode_o,
  output logic        dir_flip_o
);
  mode_t mode_q;
  logic  unused_bits;

  assign unused_bits = ^{wdata_i[15:9], wdata_i[5], wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (we_i) mode_q <= decode_mode(wdata_i);
  end

  // direction flip resets the channel
  assign dir_flip_o = we_i & (wdata_i[8] ^ mode_q.to_disk);
  assign mode_o     = mode_q;
endmodule

// File: rtl/dma_sect_cnt.sv
module dma_sect_cnt #(
  parameter int CNT_W = 8,
  parameter int NSETS = 2,
  localparam int SET_W = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        load_i,
  input  logic [SET_W-1:0]            load_set_i,
  input  logic [CNT_W-1:0]            load_val_i,
  input  logic                        dec_i,
  input  logic [SET_W-1:0]            dec_set_i,
  output logic [NSETS-1:0][CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic [CNT_W-1:0] cnt_q;
    logic             ld, dc;
    assign ld = load_i && (load_set_i == SET_W'(g));
    assign dc = dec_i && (dec_set_i == SET_W'(g)) && (cnt_q != '0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (ld)      cnt_q <= load_val_i;
      else if (dc)      cnt_q <= cnt_q - 1'b1;
    end
    assign cnt_o[g] = cnt_q;
  end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int ADDR_W = 24,
  parameter int STEP   = 512,
  localparam int NB    = ADDR_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     byte_we_i,
  input  logic [7:0]        wdata_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [NB-1:0][7:0] bytes_q;
  logic [ADDR_W-1:0]  nxt;
  logic               adv_ok;

  assign nxt    = bytes_q + ADDR_W'(STEP);
  assign adv_ok = adv_i & ~|byte_we_i;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic [7:0] wv;
    if (i == 0) begin : g_lo
      assign wv = {wdata_i[7:1], 1'b0};
    end else begin : g_hi
      assign wv = wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           bytes_q[i] <= '0;
      else if (byte_we_i[i]) bytes_q[i] <= wv;
      else if (adv_ok)       bytes_q[i] <= nxt[i*8 +: 8];
    end
  end

  assign addr_o = bytes_q;
endmodule

// File: rtl/dma_mode_status.sv
module dma_mode_status
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8,
  parameter int STEP   = 512,
  localparam int NB    = ADDR_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              byte_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              bus_err_o,
  input  logic [15:0]       ctrl_rdata_i,
  output logic              ctrl_wr_o,
  output logic [1:0]        ctrl_a_o,
  output logic              reg_set_hd_o,
  output logic              cnt_sel_o,
  output logic              dma_en_o,
  output logic              path_hd_o,
  output logic              to_disk_o,
  output logic [ADDR_W-1:0] dma_addr_o,
  input  logic              err_i,
  input  logic              drq_i,
  input  logic              sector_done_i
);
  mode_t                 mode;
  logic                  dir_flip;
  logic                  mode_hit, win_hit, mode_we;
  logic                  err_q;
  logic [1:0][CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0]      cnt_cur;
  logic [NB-1:0]         addr_we;
  logic [15:0]           status, rmux;

  assign mode_hit  = sel_i == SEL_W'(SEL_MODE);
  assign win_hit   = sel_i == SEL_W'(SEL_WIN);
  assign mode_we   = wr_i & mode_hit & ~byte_i;
  assign bus_err_o = byte_i & (rd_i | wr_i) & mode_hit;
  assign ctrl_wr_o = wr_i & win_hit & ~mode.cnt_sel;

  dma_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (mode_we),
    .wdata_i    (wdata_i),
    .mode_o     (mode),
    .dir_flip_o (dir_flip)
  );

  dma_sect_cnt #(.CNT_W(CNT_W), .NSETS(2)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (dir_flip),
    .load_i     (wr_i & win_hit & mode.cnt_sel),
    .load_set_i (mode.reg_set_hd),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .dec_i      (sector_done_i),
    .dec_set_i  (mode.reg_set_hd),
    .cnt_o      (cnt_q)
  );

  for (genvar i = 0; i < NB; i++) begin : g_awe
    assign addr_we[i] = wr_i && (sel_i == SEL_W'(SEL_ALO - i));
  end

  dma_addr_ctr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_we_i (addr_we),
    .wdata_i   (wdata_i[7:0]),
    .adv_i     (sector_done_i),
    .addr_o    (dma_addr_o)
  );

  // new error wins over a same-cycle reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (err_i)    err_q <= 1'b1;
    else if (dir_flip) err_q <= 1'b0;
  end

  assign cnt_cur = cnt_q[mode.reg_set_hd];
  assign status  = {13'd0, ~drq_i, |cnt_cur, ~err_q};

  always_comb begin
    rmux = '0;
    if (win_hit)       rmux = mode.cnt_sel ? 16'(cnt_cur) : ctrl_rdata_i;
    else if (mode_hit) rmux = byte_i ? 16'd0 : status;
    else begin
      for (int i = 0; i < NB; i++)
        if (sel_i == SEL_W'(SEL_ALO - i)) rmux = {8'd0, dma_addr_o[i*8 +: 8]};
    end
  end

  assign rdata_o      = rd_i ? rmux : 16'd0;
  assign ctrl_a_o     = mode.ctrl_a;
  assign reg_set_hd_o = mode.reg_set_hd;
  assign cnt_sel_o    = mode.cnt_sel;
  assign dma_en_o     = mode.dma_en;
  assign path_hd_o    = mode.path_hd;
  assign to_disk_o    = mode.to_disk;
endmodule

// File: rtl/dma_mode_status_chk.sv
module dma_mode_status_chk #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        sel_i,
  input logic              wr_i,
  input logic              byte_i,
  input logic [15:0]       wdata_i,
  input logic              to_disk_o,
  input logic              dma_en_o,
  input logic [ADDR_W-1:0] dma_addr_o,
  input logic              err_i,
  input logic              sector_done_i,
  input logic              err_q,
  input logic [1:0][CNT_W-1:0] cnt_q
);
  logic mode_word_wr, addr_wr;
  assign mode_word_wr = wr_i && sel_i == 3'd1 && !byte_i;
  assign addr_wr      = wr_i && (sel_i == 3'd2 || sel_i == 3'd3 || sel_i == 3'd4);

  assert_dir_stored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_word_wr |=> to_disk_o == $past(wdata_i[8]));

  assert_flip_resets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_word_wr && wdata_i[8] != to_disk_o && !err_i) |=> (!err_q && cnt_q == '0));

  assert_err_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> err_q);

  assert_byte_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && byte_i && sel_i == 3'd1) |=> ($stable(to_disk_o) && $stable(dma_en_o)));

  assert_addr_even_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_addr_o[0] == 1'b0);

  assert_addr_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sector_done_i && !addr_wr) |=> dma_addr_o == $past(dma_addr_o) + ADDR_W'(512));
endmodule

bind dma_mode_status dma_mode_status_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sel_i         (sel_i),
  .wr_i          (wr_i),
  .byte_i        (byte_i),
  .wdata_i       (wdata_i),
  .to_disk_o     (to_disk_o),
  .dma_en_o      (dma_en_o),
  .dma_addr_o    (dma_addr_o),
  .err_i         (err_i),
  .sector_done_i (sector_done_i),
  .err_q         (err_q),
  .cnt_q         (cnt_q)
);

// File: tb/dma_mode_status_tb.sv
`timescale 1ns/1ps
module dma_mode_status_tb;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  sel = 0;
  logic        rd = 0, wr = 0, byt = 0, err = 0, drq = 0, sd = 0;
  logic [15:0] wdata = 0, rdata, ctrl_rdata = 0;
  logic        bus_err, ctrl_wr, reg_set_hd, cnt_sel, dma_en, path_hd, to_disk;
  logic [1:0]  ctrl_a;
  logic [23:0] dma_addr;
  int          n_chk = 0, n_fail = 0;
  logic        last_be, last_cw;
  logic [15:0] rv;

  always #2 clk = ~clk;

  dma_mode_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .rd_i(rd), .wr_i(wr), .byte_i(byt),
    .wdata_i(wdata), .rdata_o(rdata), .bus_err_o(bus_err), .ctrl_rdata_i(ctrl_rdata),
    .ctrl_wr_o(ctrl_wr), .ctrl_a_o(ctrl_a), .reg_set_hd_o(reg_set_hd), .cnt_sel_o(cnt_sel),
    .dma_en_o(dma_en), .path_hd_o(path_hd), .to_disk_o(to_disk), .dma_addr_o(dma_addr),
    .err_i(err), .drq_i(drq), .sector_done_i(sd));

  // {mode word, expected {to_disk,path_hd,dma_en,cnt_sel,reg_set_hd,ctrl_a}}
  localparam logic [22:0] MODE_VEC [10] = '{
    {16'h0002, 7'b0000001}, {16'h0004, 7'b0000010}, {16'h0008, 7'b0000100},
    {16'h0010, 7'b0001000}, {16'h0040, 7'b0010000}, {16'h0080, 7'b0100000},
    {16'h0100, 7'b1000000}, {16'hFE21, 7'b0000000}, {16'h01DE, 7'b1111111},
    {16'h0000, 7'b0000000}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] s, input logic [15:0] d, input logic w,
                       input logic b, input logic e, input logic done);
    @(negedge clk);
    sel = s; wdata = d; wr = w; byt = b; err = e; sd = done;
    #0.5;
    last_be = bus_err; last_cw = ctrl_wr;
    @(posedge clk); #0.5;
    wr = 0; byt = 0; err = 0; sd = 0;
  endtask

  task automatic rd_reg(input logic [2:0] s, input logic b, output logic [15:0] d);
    @(negedge clk);
    sel = s; rd = 1; byt = b;
    #0.5;
    d = rdata; last_be = bus_err;
    @(posedge clk); #0.5;
    rd = 0; byt = 0;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    // R10 reset state
    rd_reg(3'd1, 0, rv); check("R10 status", rv, 16'h0005);
    check("R10 mode", {to_disk, path_hd, dma_en, cnt_sel, reg_set_hd, ctrl_a}, 0);
    check("R10 addr", dma_addr, 0);

    // R1 vector walk
    for (int i = 0; i < 10; i++) begin
      drive(3'd1, MODE_VEC[i][22:7], 1, 0, 0, 0);
      check("R1 mode bits", {to_disk, path_hd, dma_en, cnt_sel, reg_set_hd, ctrl_a},
            MODE_VEC[i][6:0]);
    end

    // R8 count load/read, R3 count bit
    drive(3'd1, 16'h0010, 1, 0, 0, 0);
    drive(3'd0, 16'h0005, 1, 0, 0, 0);
    rd_reg(3'd0, 0, rv); check("R8 floppy count", rv, 5);
    rd_reg(3'd1, 0, rv); check("R3 status count nz", rv, 16'h0007);
    drive(3'd1, 16'h0018, 1, 0, 0, 0);
    rd_reg(3'd0, 0, rv); check("R8 hd count", rv, 0);
    rd_reg(3'd1, 0, rv); check("R3 status count zero", rv, 16'h0005);
    drive(3'd0, 16'h0003, 1, 0, 0, 0);

    // R9 decrement of selected set only
    drive(3'd0, 16'h0000, 0, 0, 0, 1);
    rd_reg(3'd0, 0, rv); check("R9 hd decrement", rv, 2);
    drive(3'd1, 16'h0010, 1, 0, 0, 0);
    rd_reg(3'd0, 0, rv); check("R9 floppy untouched", rv, 5);

    // R2 flip resets counts, same bit8 does not
    drive(3'd1, 16'h0110, 1, 0, 0, 0);
    rd_reg(3'd0, 0, rv); check("R2 floppy cleared", rv, 0);
    drive(3'd1, 16'h0018, 1, 0, 0, 0);
    rd_reg(3'd0, 0, rv); check("R2 hd cleared", rv, 0);
    drive(3'd0, 16'h0004, 1, 0, 0, 0);
    drive(3'd1, 16'h001A, 1, 0, 0, 0);
    rd_reg(3'd0, 0, rv); check("R2 no flip keeps count", rv, 4);

    // R4 error sticky and flip clear
    drive(3'd0, 16'h0000, 0, 0, 1, 0);
    rd_reg(3'd1, 0, rv); check("R4 error shown", rv, 16'h0006);
    drive(3'd1, 16'h011A, 1, 0, 0, 0);
    rd_reg(3'd1, 0, rv); check("R2 error cleared by flip", rv, 16'h0005);
    drive(3'd1, 16'h001A, 1, 0, 1, 0);
    rd_reg(3'd1, 0, rv); check("R4 error wins over flip", rv, 16'h0004);

    // R3 drq active low
    drq = 1;
    rd_reg(3'd1, 0, rv); check("R3 drq bit", rv, 16'h0000);
    drq = 0;

    // R5 byte access
    drive(3'd1, 16'h0100, 1, 1, 0, 0);
    check("R5 write bus error", last_be, 1);
    check("R5 write ignored", to_disk, 0);
    rd_reg(3'd1, 1, rv);
    check("R5 read bus error", last_be, 1);
    check("R5 read data zero", rv, 0);

    // R6 address bytes
    drive(3'd2, 16'h0012, 1, 0, 0, 0);
    drive(3'd3, 16'h0034, 1, 0, 0, 0);
    drive(3'd4, 16'h0057, 1, 0, 0, 0);
    check("R6 address load", dma_addr, 24'h123456);
    rd_reg(3'd4, 0, rv); check("R6 low readback", rv, 16'h0056);

    // R7 advance, wrap, write priority
    drive(3'd0, 16'h0000, 0, 0, 0, 1);
    check("R7 advance", dma_addr, 24'h123656);
    rd_reg(3'd3, 0, rv); check("R7 mid readback", rv, 16'h0036);
    drive(3'd2, 16'h00FF, 1, 0, 0, 0);
    drive(3'd3, 16'h00FE, 1, 0, 0, 0);
    drive(3'd4, 16'h0000, 1, 0, 0, 0);
    drive(3'd0, 16'h0000, 0, 0, 0, 1);
    check("R7 wrap", dma_addr, 24'h000000);
    drive(3'd4, 16'h0010, 1, 0, 0, 1);
    check("R7 write wins", dma_addr, 24'h000010);

    // R9 saturation and flip priority
    drive(3'd1, 16'h0018, 1, 0, 0, 0);
    drive(3'd0, 16'h0000, 0, 0, 0, 1);
    rd_reg(3'd0, 0, rv); check("R9 saturate at zero", rv, 0);
    drive(3'd0, 16'h0002, 1, 0, 0, 0);
    drive(3'd1, 16'h0118, 1, 0, 0, 1);
    rd_reg(3'd0, 0, rv); check("R9 flip beats decrement", rv, 0);

    // R8 controller passthrough
    drive(3'd1, 16'h0000, 1, 0, 0, 0);
    ctrl_rdata = 16'hBEEF;
    rd_reg(3'd0, 0, rv); check("R8 controller read", rv, 16'hBEEF);
    drive(3'd0, 16'h1234, 1, 0, 0, 0);
    check("R8 controller write strobe", last_cw, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule